// File: doc/BRIEF.md
# Dual Interval Timer with Pulse Counting

This block holds the two 16-bit down-counting timers of a parallel I/O interface. Both counters advance on the phase-2 clock enable. Software sets up a timer in two steps. It first writes the low byte into a holding latch. It then writes the high byte, and that write copies the high byte and the latched low byte into the counter, arms the timer and clears its interrupt request.

Each timer sets its interrupt request once per start, on the step where the counter moves from zero to all ones. The counter keeps running after that, but it does not request again until the high byte is written again. The request is cleared by writing the high byte or by reading the counter's low byte. The second timer can also work as a pulse counter. A mode bit makes it decrement on each synchronised falling edge of an external port pin instead of on each phase-2 step.

The bus is a simple chip-select register port. An access takes effect only in a cycle where both `cs` and `ph2_en` are high. Read data is combinational from the current counter value.

Top module: `dual_timer`

## Requirements
- R1: After reset both counters, latches and the mode bit are zero, both timers are disarmed and both interrupt outputs are low. A disarmed counter wraps from zero without raising a request. Reading address 11 returns 0x00.
- R2: A write to address 4 (timer 1) or address 8 (timer 2) only updates that timer's low-byte latch. It changes neither the counter nor the interrupt request.
- R3: A write to address 5 or address 9 loads that timer's counter with {written byte, latched low byte}. In the same cycle it arms the timer and clears its request. A load has priority over a decrement in that cycle.
- R4: Reading address 5 or 9 returns the current counter high byte. Reading address 4 or 8 returns the current counter low byte. Other addresses read 0x00, except address 11.
- R5: An armed counter that was loaded with N raises its request on exactly the (N+1)-th counting step after the load.
- R6: The request fires once per start. After the timeout the counter keeps decrementing and wraps again without raising a new request.
- R7: A write to the high-byte address clears a pending request and restarts the count.
- R8: A read of the low-counter address clears the request. A read of the high-byte address leaves the request as it is.
- R9: Timer 2 follows R2 to R8 through addresses 8 and 9 and drives `t2_irq`. `t1_irq` reports interrupt-flag bit 6 and `t2_irq` reports flag bit 5.
- R10: Bit 5 of the mode register (address 11, readable) selects pulse counting for timer 2. In that mode timer 2 ignores phase-2 steps and decrements once per falling edge of `pb6_in`. Rising edges have no effect. The edge passes through two synchroniser stages, so the counter changes at the third enabled edge after the pin falls.
- R11: While `ph2_en` is low, both counters and both requests hold their values, and bus accesses have no effect.
- R12: If a counting step that raises a request coincides with a read of that timer's low counter, the request ends up set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ph2_en | input | 1 | Phase-2 step enable |
| cs | input | 1 | Register select |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | 4 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data (combinational) |
| pb6_in | input | 1 | External pulse input for timer 2 |
| t1_irq | output | 1 | Timer 1 request (flag bit 6) |
| t2_irq | output | 1 | Timer 2 request (flag bit 5) |

## Verification
Two of this block's functions can land in the same cycle: a counting step that times out, and a read of the low counter that clears the request. The bench loads timer 1 with 2 and then idles for exactly two steps. That places the low-counter read on the edge where the counter passes from zero to all ones. The read must return 0x00, and the request must be high in the following cycle. A second read must then clear it, which shows that the timeout won the tie and the clear did not swallow it.

// File: rtl/dtmr_pkg.sv
package dtmr_pkg;
    localparam int BYTE_W    = 8;
    localparam int CNT_W     = 2 * BYTE_W;
    localparam int ADDR_W    = 4;
    localparam int NUM_TMR   = 2;
    localparam int PULSE_TMR = 1;
    localparam int PULSE_BIT = 5;
    localparam int SYNC_LEN  = 2;

    localparam logic [ADDR_W-1:0] A_T1_LO = 4'd4;
    localparam logic [ADDR_W-1:0] A_T1_HI = 4'd5;
    localparam logic [ADDR_W-1:0] A_T2_LO = 4'd8;
    localparam logic [ADDR_W-1:0] A_T2_HI = 4'd9;
    localparam logic [ADDR_W-1:0] A_MODE  = 4'd11;

    typedef struct packed {
        logic [CNT_W-1:0]  cnt;
        logic [BYTE_W-1:0] lat;
        logic              armed;
        logic              flag;
    } tmr_state_t;

    typedef struct packed {
        logic pulse;
    } ctl_state_t;

    function automatic logic [ADDR_W-1:0] lo_addr(input int idx);
        return (idx == 0) ? A_T1_LO : A_T2_LO;
    endfunction

    function automatic logic [ADDR_W-1:0] hi_addr(input int idx);
        return (idx == 0) ? A_T1_HI : A_T2_HI;
    endfunction
endpackage

// File: rtl/pb_fall_sync.sv
module pb_fall_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic pin,
    output logic fall
);
    localparam int LEN = STAGES + 1;

    logic [LEN-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = sh_q;
        if (en) sh_d = {sh_q[LEN-2:0], pin};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    // older sample high, newer sample low: a falling edge
    assign fall = sh_q[LEN-1] & ~sh_q[LEN-2];
endmodule

// File: rtl/tmr_unit.sv
module tmr_unit
    import dtmr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              wr_lo,
    input  logic              wr_hi,
    input  logic              rd_lo,
    input  logic [BYTE_W-1:0] wdata,
    output logic [CNT_W-1:0]  cnt,
    output logic              flag
);
    tmr_state_t st_d, st_q;
    logic       timeout;

    assign timeout = tick && (st_q.cnt == '0) && st_q.armed;

    always_comb begin
        st_d = st_q;
        if (wr_lo) st_d.lat = wdata;
        if (wr_hi) begin
            st_d.cnt   = {wdata, st_q.lat};
            st_d.armed = 1'b1;
            st_d.flag  = 1'b0;
        end else begin
            if (tick) st_d.cnt = st_q.cnt - CNT_W'(1);
            if (timeout) begin
                st_d.flag  = 1'b1;
                st_d.armed = 1'b0;
            end else if (rd_lo) begin
                st_d.flag = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt  = st_q.cnt;
    assign flag = st_q.flag;
endmodule

// File: rtl/dual_timer.sv
module dual_timer
    import dtmr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ph2_en,
    input  logic              cs,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BYTE_W-1:0] wdata,
    output logic [BYTE_W-1:0] rdata,
    input  logic              pb6_in,
    output logic              t1_irq,
    output logic              t2_irq
);
    logic             acc_wr, acc_rd, pb_fall;
    logic [CNT_W-1:0] cnt_w  [NUM_TMR];
    logic             flag_w [NUM_TMR];
    ctl_state_t       ctl_d, ctl_q;

    assign acc_wr = ph2_en & cs & we;
    assign acc_rd = ph2_en & cs & ~we;

    always_comb begin
        ctl_d = ctl_q;
        if (acc_wr && addr == A_MODE) ctl_d.pulse = wdata[PULSE_BIT];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    pb_fall_sync #(.STAGES(SYNC_LEN)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .en   (ph2_en),
        .pin  (pb6_in),
        .fall (pb_fall)
    );

    for (genvar i = 0; i < NUM_TMR; i++) begin : g_tmr
        logic tick;
        if (i == PULSE_TMR) begin : g_pulse
            assign tick = ph2_en & (ctl_q.pulse ? pb_fall : 1'b1);
        end else begin : g_plain
            assign tick = ph2_en;
        end
        tmr_unit u_tmr (
            .clk  (clk),
            .rst_n(rst_n),
            .tick (tick),
            .wr_lo(acc_wr && addr == lo_addr(i)),
            .wr_hi(acc_wr && addr == hi_addr(i)),
            .rd_lo(acc_rd && addr == lo_addr(i)),
            .wdata(wdata),
            .cnt  (cnt_w[i]),
            .flag (flag_w[i])
        );
    end

    always_comb begin
        rdata = '0;
        if (cs) begin
            for (int i = 0; i < NUM_TMR; i++) begin
                if (addr == lo_addr(i)) rdata = cnt_w[i][BYTE_W-1:0];
                if (addr == hi_addr(i)) rdata = cnt_w[i][CNT_W-1:BYTE_W];
            end
            if (addr == A_MODE) rdata[PULSE_BIT] = ctl_q.pulse;
        end
    end

    assign t1_irq = flag_w[0];
    assign t2_irq = flag_w[1];
endmodule

// File: rtl/dual_timer_chk.sv
module dual_timer_chk
    import dtmr_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              ph2_en,
    input logic              cs,
    input logic              we,
    input logic [ADDR_W-1:0] addr,
    input logic              t1_irq,
    input logic              t2_irq,
    input logic [CNT_W-1:0]  t1_cnt,
    input logic [CNT_W-1:0]  t2_cnt
);
    // R7: high-byte write leaves the request low
    assert_hi_write_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ph2_en && cs && we && addr == A_T1_HI) |=> !t1_irq);

    // R9: same rule for timer 2
    assert_t2_hi_write_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ph2_en && cs && we && addr == A_T2_HI) |=> !t2_irq);

    // R8: a low read away from a timeout clears the request
    assert_lo_read_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ph2_en && cs && !we && addr == A_T1_LO && t1_cnt != '0) |=> !t1_irq);

    // R5: a request only rises after the counter sat at zero
    assert_rise_from_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(t1_irq) |-> ($past(t1_cnt) == '0));

    assert_t2_rise_from_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(t2_irq) |-> ($past(t2_cnt) == '0));

    // R11: nothing moves without the phase-2 enable
    assert_hold_without_enable_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !ph2_en |=> ($stable(t1_cnt) && $stable(t2_cnt) && $stable(t1_irq) && $stable(t2_irq)));
endmodule

bind dual_timer dual_timer_chk u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .ph2_en(ph2_en),
    .cs    (cs),
    .we    (we),
    .addr  (addr),
    .t1_irq(t1_irq),
    .t2_irq(t2_irq),
    .t1_cnt(cnt_w[0]),
    .t2_cnt(cnt_w[1])
);

// File: tb/sim_dual_timer.sv
module sim_dual_timer;
    logic       clk = 1'b0;
    logic       rst_n, ph2_en, cs, we, pb6_in;
    logic [3:0] addr;
    logic [7:0] wdata, rdata, v;
    logic       t1_irq, t2_irq;
    int         total = 0, bad = 0;
    bit         done = 0;

    always #4 clk = ~clk;

    dual_timer u0 (
        .clk(clk), .rst_n(rst_n), .ph2_en(ph2_en), .cs(cs), .we(we),
        .addr(addr), .wdata(wdata), .rdata(rdata), .pb6_in(pb6_in),
        .t1_irq(t1_irq), .t2_irq(t2_irq)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        cs = 1; we = 1; addr = a; wdata = d;
        @(negedge clk);
        cs = 0; we = 0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] d);
        cs = 1; we = 0; addr = a;
        #1 d = rdata;
        @(negedge clk);
        cs = 0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset;
        chk("R1 t1_irq in reset", 16'(t1_irq), 0);
        chk("R1 t2_irq in reset", 16'(t2_irq), 0);
        rst_n = 1;
        idle(5);
        chk("R1 no request on unarmed wrap t1", 16'(t1_irq), 0);
        chk("R1 no request on unarmed wrap t2", 16'(t2_irq), 0);
        rd(4'd11, v);
        chk("R1 mode reads zero", 16'(v), 0);
    endtask

    task automatic t_load;
        wr(4'd4, 8'h34);
        wr(4'd5, 8'h12);
        rd(4'd5, v);
        chk("R3 high byte after load", 16'(v), 16'h12);
        rd(4'd4, v);
        chk("R4 low byte after one step", 16'(v), 16'h33);
        rd(4'd3, v);
        chk("R4 unused address reads zero", 16'(v), 0);
    endtask

    task automatic t_underflow;
        wr(4'd4, 8'd5);
        wr(4'd5, 8'd0);
        idle(5);
        chk("R5 no request at zero", 16'(t1_irq), 0);
        idle(1);
        chk("R5 request on step N+1", 16'(t1_irq), 1);
        chk("R5 timer 2 untouched", 16'(t2_irq), 0);
        wr(4'd4, 8'h77);
        chk("R2 low write keeps request", 16'(t1_irq), 1);
        rd(4'd5, v);
        chk("R8 high read keeps request", 16'(t1_irq), 1);
        rd(4'd4, v);
        chk("R8 low read clears request", 16'(t1_irq), 0);
    endtask

    task automatic t_oneshot;
        bit seen = 0;
        wr(4'd4, 8'd3);
        wr(4'd5, 8'd0);
        idle(4);
        chk("R6 first timeout", 16'(t1_irq), 1);
        rd(4'd4, v);
        for (int k = 0; k < 65546; k++) begin
            @(negedge clk);
            if (t1_irq) seen = 1;
        end
        chk("R6 no second request after wrap", 16'(seen), 0);
    endtask

    task automatic t_hiclear;
        wr(4'd4, 8'd2);
        wr(4'd5, 8'd0);
        idle(3);
        chk("R7 request before rewrite", 16'(t1_irq), 1);
        wr(4'd5, 8'd0);
        chk("R7 high write clears", 16'(t1_irq), 0);
        idle(3);
        chk("R7 restarted count times out", 16'(t1_irq), 1);
        rd(4'd4, v);
    endtask

    task automatic t_coincide;
        wr(4'd4, 8'd2);
        wr(4'd5, 8'd0);
        idle(2);
        rd(4'd4, v);
        chk("R12 read sees zero", 16'(v), 0);
        chk("R12 timeout beats read clear", 16'(t1_irq), 1);
        rd(4'd4, v);
        chk("R12 later read clears", 16'(t1_irq), 0);
    endtask

    task automatic t_timer2;
        wr(4'd8, 8'd4);
        wr(4'd9, 8'd0);
        idle(4);
        chk("R9 t2 no request at zero", 16'(t2_irq), 0);
        idle(1);
        chk("R9 t2 request on step N+1", 16'(t2_irq), 1);
        wr(4'd9, 8'h01);
        chk("R9 t2 high write clears", 16'(t2_irq), 0);
        rd(4'd9, v);
        chk("R9 t2 high byte", 16'(v), 16'h01);
        rd(4'd8, v);
        chk("R9 t2 low byte", 16'(v), 16'h03);
        wr(4'd8, 8'd1);
        wr(4'd9, 8'd0);
        idle(2);
        chk("R9 t2 request again", 16'(t2_irq), 1);
        rd(4'd8, v);
        chk("R9 t2 low read clears", 16'(t2_irq), 0);
    endtask

    task automatic t_pulse;
        wr(4'd11, 8'h20);
        rd(4'd11, v);
        chk("R10 mode bit readback", 16'(v), 16'h20);
        wr(4'd8, 8'd1);
        wr(4'd9, 8'd0);
        idle(10);
        rd(4'd8, v);
        chk("R10 no decrement on clock steps", 16'(v), 16'h01);
        pb6_in = 0;
        idle(2);
        rd(4'd8, v);
        chk("R10 not yet through synchroniser", 16'(v), 16'h01);
        idle(1);
        rd(4'd8, v);
        chk("R10 decrement on falling edge", 16'(v), 0);
        pb6_in = 1;
        idle(6);
        rd(4'd8, v);
        chk("R10 rising edge ignored", 16'(v), 0);
        chk("R10 no request yet", 16'(t2_irq), 0);
        pb6_in = 0;
        idle(6);
        chk("R10 request on second falling edge", 16'(t2_irq), 1);
        wr(4'd11, 8'h00);
        rd(4'd8, v);
        pb6_in = 1;
    endtask

    task automatic t_enable;
        wr(4'd4, 8'd9);
        wr(4'd5, 8'd0);
        ph2_en = 0;
        idle(20);
        wr(4'd5, 8'h55);
        ph2_en = 1;
        rd(4'd5, v);
        chk("R11 write ignored without enable", 16'(v), 0);
        rd(4'd4, v);
        chk("R11 counter held without enable", 16'(v), 16'h08);
    endtask

    initial begin
        rst_n = 0; ph2_en = 1; cs = 0; we = 0; addr = '0; wdata = '0; pb6_in = 1;
        idle(3);
        t_reset();
        t_load();
        t_underflow();
        t_oneshot();
        t_hiclear();
        t_coincide();
        t_timer2();
        t_pulse();
        t_enable();
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(8 * 190000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule